// File: doc/BRIEF.md
# SDRAM Byte-Lane Mask Stage

This block sits between the burst data path of a 16-bit SDRAM device and its data pins. It applies the per-byte mask inputs, one bit for the upper byte and one for the lower byte. Read masks and write masks take effect at different times.

On reads, each mask bit passes through a delay line of two clocks. It then decides whether its byte lane drives the pins in the beat two cycles later, or stays in high impedance. On writes, the mask acts in the same cycle as the data. It produces a per-lane write strobe, so a masked lane leaves its stored byte unchanged.

The read delay line is cleared when a read burst is cut short. Without that clear, a mask left over from the cut burst could disable the first beats of the next burst. The lane count and the read latency are parameters, so the same stage also serves a narrow organization with a single mask bit.

Top module: `sdram_lane_mask`

## Requirements
- R1: The output enable of a lane in a read beat follows that lane's mask bit as driven two clock cycles earlier. A mask driven together with a read beat has no effect on that beat.
- R2: In a read beat, a lane whose delayed mask bit is 1 has its output enable at 0 and its read data lane at 0. A lane whose delayed mask bit is 0 has its output enable at 1 and passes the read data unchanged.
- R3: In a write beat, the write strobe of a lane is the inverse of that lane's mask bit in the same cycle. A masked lane carries zero write data and an unmasked lane carries the write data unchanged.
- R4: Mask bit 1 (upper) governs data bits 15..8 and mask bit 0 (lower) governs data bits 7..0, on both the read and the write path.
- R5: The mask may change on every beat, so each word of a burst is masked or enabled on its own.
- R6: When the read valid strobe falls at the end of a burst, both output enables return to 0 in that same cycle.
- R7: A read abort pulse clears the delay line. The two read beats that follow the abort cycle use a mask of 0 on both lanes, whatever masks were driven up to and including the abort cycle.
- R8: With neither read nor write valid, both write strobes and both output enables are 0 and both data outputs are 0.
- R9: When write valid is high, both output enables are 0, even if read valid is also high.
- R10: While reset is asserted and until the first masks are clocked in after reset, the delay line holds 0, so the first two read beats after reset are unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_mask_i | input | 2 | Byte mask, bit 1 upper, bit 0 lower |
| rd_beat_i | input | 1 | Read data beat valid this cycle |
| rd_abort_i | input | 1 | Read burst cut short; clears the delay line |
| wr_beat_i | input | 1 | Write data beat valid this cycle |
| rd_data_i | input | 16 | Read data from the array |
| wr_data_i | input | 16 | Write data from the pins |
| pin_data_o | output | 16 | Read data toward the pins, zero on disabled lanes |
| pin_oe_o | output | 2 | Per-lane output enable toward the pins |
| wr_strobe_o | output | 2 | Per-lane write strobe toward the array |
| wr_data_o | output | 16 | Write data toward the array, zero on masked lanes |

## Verification
The assertions check, on every cycle, that the write strobes and the output enables never overlap, and that every output is quiet when no beat is valid. They also check that a disabled lane carries zero data and that an abort leaves a cleared delay line. Only the bench's scenarios can show the two-cycle read latency against the zero-cycle write latency, and that masks change word by word within a burst. The bench also shows the exact beats that an abort or a reset exempts from masking.

// File: rtl/sdram_mask_pkg.sv
package sdram_mask_pkg;

  // lowest bit index of a byte lane within the data word
  function automatic int unsigned lane_base(int unsigned lane, int unsigned lane_w);
    return lane * lane_w;
  endfunction

  // a lane is active when its beat is valid and its mask is clear
  function automatic logic lane_active(logic beat, logic blocked, logic mask);
    return beat & ~blocked & ~mask;
  endfunction

endpackage

// File: rtl/sdram_rd_mask_delay.sv
module sdram_rd_mask_delay #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] mask_i,
  input  logic             clear_i,
  output logic [LANES-1:0] mask_late_o
);

  logic [LANES-1:0] stage_q [RD_LAT];

  generate
    for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
      logic [LANES-1:0] stage_d;
      if (s == 0) begin : g_head
        assign stage_d = mask_i;
      end else begin : g_body
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stage_q[s] <= '0;
        else if (clear_i) stage_q[s] <= '0;
        else              stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign mask_late_o = stage_q[RD_LAT-1];

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (mask_late_o == '0));

endmodule

// File: rtl/sdram_lane_gate.sv
module sdram_lane_gate #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic [LANES-1:0] en_i,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    data_o
);
  import sdram_mask_pkg::*;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int unsigned LO = lane_base(l, LANE_W);
      assign data_o[LO +: LANE_W] = en_i[l] ? data_i[LO +: LANE_W] : '0;
    end
  endgenerate

endmodule

// File: rtl/sdram_lane_mask.sv
module sdram_lane_mask #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned RD_LAT = 2,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_mask_i,
  input  logic             rd_beat_i,
  input  logic             rd_abort_i,
  input  logic             wr_beat_i,
  input  logic [DW-1:0]    rd_data_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    pin_data_o,
  output logic [LANES-1:0] pin_oe_o,
  output logic [LANES-1:0] wr_strobe_o,
  output logic [DW-1:0]    wr_data_o
);
  import sdram_mask_pkg::*;

  logic [LANES-1:0] rd_mask_late;
  logic [LANES-1:0] rd_lane_en;
  logic [LANES-1:0] wr_lane_en;
  logic             idle_cycle;

  sdram_rd_mask_delay #(.LANES(LANES), .RD_LAT(RD_LAT)) rd_dly_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_i      (lane_mask_i),
    .clear_i     (rd_abort_i),
    .mask_late_o (rd_mask_late)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_en
      assign rd_lane_en[l] = lane_active(rd_beat_i, wr_beat_i, rd_mask_late[l]);
      assign wr_lane_en[l] = lane_active(wr_beat_i, 1'b0, lane_mask_i[l]);
    end
  endgenerate

  sdram_lane_gate #(.LANES(LANES), .LANE_W(LANE_W)) rd_gate_i (
    .en_i   (rd_lane_en),
    .data_i (rd_data_i),
    .data_o (pin_data_o)
  );

  sdram_lane_gate #(.LANES(LANES), .LANE_W(LANE_W)) wr_gate_i (
    .en_i   (wr_lane_en),
    .data_i (wr_data_i),
    .data_o (wr_data_o)
  );

  assign pin_oe_o    = rd_lane_en;
  assign wr_strobe_o = wr_lane_en;
  assign idle_cycle  = ~rd_beat_i & ~wr_beat_i;

  // R9
  no_turnaround_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|pin_oe_o) && (|wr_strobe_o)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cycle |-> (pin_oe_o == '0 && wr_strobe_o == '0 && pin_data_o == '0 && wr_data_o == '0));

  // R6
  rd_end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_beat_i |-> (pin_oe_o == '0));

  // R2
  rd_lane_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe_o == '0) |-> (pin_data_o == '0));

  // R3
  wr_lane_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe_o == '0) |-> (wr_data_o == '0));

  // R3
  wr_mask_honoured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe_o & lane_mask_i) == '0);

endmodule

// File: tb/sdram_lane_mask_tb.sv
module sdram_lane_mask_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  lane_mask_i = '0;
  logic        rd_beat_i = 1'b0, rd_abort_i = 1'b0, wr_beat_i = 1'b0;
  logic [15:0] rd_data_i = '0, wr_data_i = '0;
  logic [15:0] pin_data_o, wr_data_o;
  logic [1:0]  pin_oe_o, wr_strobe_o;

  int checks = 0;
  int fails  = 0;
  logic [1:0] hist1 = '0, hist2 = '0; // masks driven one and two steps back (0 if cleared)

  always #5 clk = ~clk;

  sdram_lane_mask dut_i (
    .clk(clk), .rst_n(rst_n), .lane_mask_i(lane_mask_i),
    .rd_beat_i(rd_beat_i), .rd_abort_i(rd_abort_i), .wr_beat_i(wr_beat_i),
    .rd_data_i(rd_data_i), .wr_data_i(wr_data_i),
    .pin_data_o(pin_data_o), .pin_oe_o(pin_oe_o),
    .wr_strobe_o(wr_strobe_o), .wr_data_o(wr_data_o)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] widen(input logic [1:0] en);
    return {{8{en[1]}}, {8{en[0]}}};
  endfunction

  // one beat: drive after the falling edge, check before the rising edge
  task automatic beat(input logic [1:0] m, input bit rv, input bit wv, input bit ab,
                      input logic [15:0] rd, input logic [15:0] wd, input string req);
    logic [1:0] exp_oe, exp_stb;
    @(negedge clk);
    lane_mask_i = m; rd_beat_i = rv; wr_beat_i = wv; rd_abort_i = ab;
    rd_data_i = rd; wr_data_i = wd;
    #2;
    exp_oe  = (rv && !wv) ? ~hist2 : 2'b00;
    exp_stb = wv ? ~m : 2'b00;
    chk(pin_oe_o == exp_oe, req, {14'd0, pin_oe_o}, {14'd0, exp_oe});
    chk(pin_data_o == (rd & widen(exp_oe)), req, pin_data_o, rd & widen(exp_oe));
    chk(wr_strobe_o == exp_stb, req, {14'd0, wr_strobe_o}, {14'd0, exp_stb});
    chk(wr_data_o == (wd & widen(exp_stb)), req, wr_data_o, wd & widen(exp_stb));
    if (ab) begin hist2 = '0; hist1 = '0; end
    else begin hist2 = hist1; hist1 = m; end
  endtask

  task automatic t_reset;
    // R10: outputs quiet in reset, first two read beats unmasked
    #1;
    chk(pin_oe_o == 2'b00 && wr_strobe_o == 2'b00, "R10", {14'd0, pin_oe_o}, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    hist1 = '0; hist2 = '0;
    beat(2'b11, 1, 0, 0, 16'hA1B2, 16'h0, "R10");
    beat(2'b11, 1, 0, 0, 16'hC3D4, 16'h0, "R10");
    beat(2'b00, 1, 0, 0, 16'hE5F6, 16'h0, "R1");
    beat(2'b00, 0, 0, 0, 16'h1234, 16'h0, "R6");
  endtask

  task automatic t_read_latency;
    // R1 R2 R4 R5: masks change per beat, effect two beats later
    beat(2'b00, 0, 0, 0, 16'h0000, 16'h0, "R8");
    beat(2'b10, 0, 0, 0, 16'h0000, 16'h0, "R8");
    beat(2'b01, 1, 0, 0, 16'h1111, 16'h0, "R1");
    beat(2'b11, 1, 0, 0, 16'h2222, 16'h0, "R1");
    beat(2'b00, 1, 0, 0, 16'h3344, 16'h0, "R4");
    beat(2'b10, 1, 0, 0, 16'h5566, 16'h0, "R2");
    beat(2'b00, 1, 0, 0, 16'h7788, 16'h0, "R5");
    beat(2'b00, 1, 0, 0, 16'h99AA, 16'h0, "R5");
    beat(2'b00, 0, 0, 0, 16'hBBCC, 16'h0, "R6");
  endtask

  task automatic t_write;
    // R3 R4 R5: zero latency per lane
    beat(2'b00, 0, 1, 0, 16'h0, 16'hDEAD, "R3");
    beat(2'b10, 0, 1, 0, 16'h0, 16'hBEEF, "R4");
    beat(2'b01, 0, 1, 0, 16'h0, 16'hCAFE, "R4");
    beat(2'b11, 0, 1, 0, 16'h0, 16'hF00D, "R3");
    beat(2'b00, 0, 1, 0, 16'h0, 16'h1357, "R5");
    beat(2'b00, 0, 0, 0, 16'h0, 16'h2468, "R8");
  endtask

  task automatic t_abort;
    // R7: masks up to the abort cycle never reach later beats
    beat(2'b11, 1, 0, 0, 16'hAAAA, 16'h0, "R7");
    beat(2'b11, 1, 0, 1, 16'hBBBB, 16'h0, "R7");
    beat(2'b10, 1, 0, 0, 16'hCCCC, 16'h0, "R7");
    beat(2'b01, 1, 0, 0, 16'hDDDD, 16'h0, "R7");
    beat(2'b00, 1, 0, 0, 16'hEEEE, 16'h0, "R7");
    beat(2'b00, 1, 0, 0, 16'hFFFF, 16'h0, "R7");
    beat(2'b00, 0, 0, 0, 16'h0, 16'h0, "R6");
  endtask

  task automatic t_priority;
    // R9: a write beat keeps the read lanes off
    beat(2'b00, 1, 0, 0, 16'h0F0F, 16'h0, "R9");
    beat(2'b01, 1, 1, 0, 16'h0F0F, 16'hF0F0, "R9");
    beat(2'b00, 1, 1, 0, 16'h0F0F, 16'hA5A5, "R9");
    beat(2'b00, 1, 0, 0, 16'h0F0F, 16'h0, "R9");
    beat(2'b00, 0, 0, 0, 16'h0, 16'h0, "R8");
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_read_latency;
        t_write;
        t_abort;
        t_priority;
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule